// File: doc/BRIEF.md
# PFC Gate Control Supervisor

This block decides, every clock, whether the boost power stage gate is driven. It sits between the PWM comparator output and the gate driver. It passes the per-cycle PWM request through, but a switching-period counter limits the on-time and guarantees an off-time in every period. Fast fault flags cut the running pulse for the rest of the period. Slow faults and standby hold the gate off until a soft-start strobe arrives after those faults have gone.

A digitised output-voltage code is compared with a reference code using integer percentages, so no division is needed. The comparison yields three results:
- a request to raise the error amplifier gain when the output strays more than 5% from the reference;
- a compensation pull-down request above 107%;
- a hysteretic over-voltage gate lock, which sets above 109% and releases below 102%.

A compensation discharge request is raised while any latching fault or standby is present. All outputs are registered.

Top module: `pfc_gate_sup`

## Requirements
- R1: `gate_o` is high for at most MAX_ON = min(floor(PERIOD_CYC*49/50), PERIOD_CYC-1) clock cycles of each PERIOD_CYC-cycle switching period. It is low in the first cycle of every period. With defaults, and the request held high, the pattern is 49 cycles high and 1 cycle low.
- R2: With no fault, inhibit or lock, `gate_o` follows `pwm_req_i` one clock later, inside the allowed on-window.
- R3: A high `ovp_hi_i` or `pk_ilim_i` forces `gate_o` low from the next clock until the end of the current period. These flags do not latch, and the gate may turn on again in the next period.
- R4: A high `uvlo_i`, `pin_flt_a_i`, `pin_flt_b_i` or `standby_i` forces `gate_o` low from the next clock and sets the inhibit.
- R5: The inhibit clears only on a clock where `ss_start_i` is high and all four latching inputs are low. `gate_o` can rise at the earliest two clocks after that strobe.
- R6: `comp_dis_o` is high one clock after any of the four latching inputs is high, and low one clock after all four are low.
- R7: `gain_boost_o` is high one clock after 100·code > 105·ref or 100·code < 95·ref, and low otherwise.
- R8: `comp_pull_o` is high one clock after 100·code > 107·ref, and low otherwise.
- R9: The over-voltage lock sets one clock after 100·code > 109·ref and clears one clock after 100·code < 102·ref; between those levels it holds. While the lock is set, `gate_o` is low from the next clock.
- R10: During and after reset, all outputs are low and the inhibit is set. The gate stays low until a soft-start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_req_i | input | 1 | PWM comparator request |
| vout_code_i | input | CODE_W | Sampled output-voltage code |
| vref_code_i | input | CODE_W | Regulation reference code |
| ovp_hi_i | input | 1 | Over-voltage high, cycle-by-cycle |
| pk_ilim_i | input | 1 | Peak current limit, cycle-by-cycle |
| uvlo_i | input | 1 | Supply undervoltage lockout |
| pin_flt_a_i | input | 1 | First open/short pin fault |
| pin_flt_b_i | input | 1 | Second open/short pin fault |
| standby_i | input | 1 | Overload / standby |
| ss_start_i | input | 1 | Soft-start begin strobe |
| gate_o | output | 1 | Gate drive |
| gain_boost_o | output | 1 | Error-amplifier gain boost request |
| comp_pull_o | output | 1 | Compensation pull-down request |
| comp_dis_o | output | 1 | Compensation discharge request |

## Verification
The bench holds the request high across whole periods and measures the longest high run. A counter that wraps one cycle late, or an off-by-one in the on-window, would show up as a run of 50 or a period with no low cycle. It pulses the fast faults mid-period: a design that merely gates the pulse, without ending it, would re-raise the gate in the same period. It raises the soft-start strobe while a latching fault is still present, which catches an inhibit that releases on the strobe alone. It sweeps the voltage code up past 109% and back down through the 102–109% band: a lock without hysteresis would release the gate inside that band.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;
  typedef struct packed {
    logic uvlo;
    logic pin_a;
    logic pin_b;
    logic stby;
  } lat_flt_t;

  localparam int unsigned ON_NUM = 49;
  localparam int unsigned ON_DEN = 50;
endpackage

// File: rtl/pfc_period_ctr.sv
module pfc_period_ctr #(
  parameter int unsigned PERIOD_CYC = 50,
  localparam int unsigned CNT_W = $clog2(PERIOD_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pfc_vmon.sv
module pfc_vmon #(
  parameter int unsigned CODE_W = 12,
  localparam int unsigned PW = CODE_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] ref_i,
  output logic              boost_o,
  output logic              pull_o,
  output logic              lock_o
);
  logic [PW-1:0] c100;
  logic [PW-1:0] r095, r102, r105, r107, r109;
  logic          boost_d, pull_d, set_lk, clr_lk;
  logic          boost_q, pull_q, lock_q;

  always_comb begin
    c100    = PW'(code_i) * PW'(100);
    r095    = PW'(ref_i) * PW'(95);
    r102    = PW'(ref_i) * PW'(102);
    r105    = PW'(ref_i) * PW'(105);
    r107    = PW'(ref_i) * PW'(107);
    r109    = PW'(ref_i) * PW'(109);
    boost_d = (c100 > r105) || (c100 < r095);
    pull_d  = (c100 > r107);
    set_lk  = (c100 > r109);
    clr_lk  = (c100 < r102);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boost_q <= 1'b0;
      pull_q  <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      boost_q <= boost_d;
      pull_q  <= pull_d;
      if (set_lk)      lock_q <= 1'b1;
      else if (clr_lk) lock_q <= 1'b0;
    end
  end

  assign boost_o = boost_q;
  assign pull_o  = pull_q;
  assign lock_o  = lock_q;

  // pull-down threshold sits above the boost band
  p_pull_in_boost_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_q |-> boost_q);
  // set needs >109%, so a rise implies the code was above 102% a cycle ago
  p_lock_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> !$past(clr_lk));
endmodule

// File: rtl/pfc_fault_latch.sv
module pfc_fault_latch
  import pfc_gate_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  lat_flt_t flt_i,
  input  logic     ss_start_i,
  output logic     any_o,
  output logic     inh_o,
  output logic     dis_o
);
  logic any_flt;
  logic inh_q, dis_q;

  assign any_flt = |flt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inh_q <= 1'b1;
      dis_q <= 1'b0;
    end else begin
      dis_q <= any_flt;
      if (any_flt)         inh_q <= 1'b1;
      else if (ss_start_i) inh_q <= 1'b0;
    end
  end

  assign any_o = any_flt;
  assign inh_o = inh_q;
  assign dis_o = dis_q;

  p_release_on_ss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inh_q) |-> $past(ss_start_i) && !$past(any_flt));
  p_dis_implies_inh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |-> inh_q);
endmodule

// File: rtl/pfc_gate_sup.sv
module pfc_gate_sup
  import pfc_gate_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 50,
  parameter int unsigned CODE_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_req_i,
  input  logic [CODE_W-1:0] vout_code_i,
  input  logic [CODE_W-1:0] vref_code_i,
  input  logic              ovp_hi_i,
  input  logic              pk_ilim_i,
  input  logic              uvlo_i,
  input  logic              pin_flt_a_i,
  input  logic              pin_flt_b_i,
  input  logic              standby_i,
  input  logic              ss_start_i,
  output logic              gate_o,
  output logic              gain_boost_o,
  output logic              comp_pull_o,
  output logic              comp_dis_o
);
  localparam int unsigned CNT_W   = $clog2(PERIOD_CYC);
  localparam int unsigned ON_RAW  = (PERIOD_CYC * ON_NUM) / ON_DEN;
  localparam int unsigned MAX_ON  = (ON_RAW > PERIOD_CYC - 1) ? PERIOD_CYC - 1 : ON_RAW;
  localparam logic [CNT_W-1:0] MAX_ON_C = CNT_W'(MAX_ON);

  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             lat_any, inh, ov_lock;
  logic             fast_flt, term_q, gate_q, gate_d;
  lat_flt_t         lflt;

  assign lflt = '{uvlo: uvlo_i, pin_a: pin_flt_a_i, pin_b: pin_flt_b_i, stby: standby_i};

  pfc_period_ctr #(.PERIOD_CYC(PERIOD_CYC)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .last_o(last)
  );

  pfc_vmon #(.CODE_W(CODE_W)) u_vmon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (vout_code_i),
    .ref_i  (vref_code_i),
    .boost_o(gain_boost_o),
    .pull_o (comp_pull_o),
    .lock_o (ov_lock)
  );

  pfc_fault_latch u_flt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flt_i     (lflt),
    .ss_start_i(ss_start_i),
    .any_o     (lat_any),
    .inh_o     (inh),
    .dis_o     (comp_dis_o)
  );

  assign fast_flt = ovp_hi_i | pk_ilim_i;

  always_comb begin
    gate_d = pwm_req_i && (cnt < MAX_ON_C) && !fast_flt && !term_q
             && !inh && !lat_any && !ov_lock;
  end

  // a pulse cut by a fast fault stays cut until the period wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      term_q <= last ? 1'b0 : (term_q | fast_flt);
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;

  p_min_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |-> !gate_q);
  p_fast_cut_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_flt |=> !gate_q);
  p_latch_cut_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_any |=> !gate_q);
  p_inh_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh |=> !gate_q);
  p_lock_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_lock |=> !gate_q);
endmodule

// File: tb/pfc_gate_sup_tb.sv
module pfc_gate_sup_tb_top;
  localparam int P      = 50;
  localparam int MAXON  = 49;
  localparam int CW     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 0, ovp = 0, pcl = 0, uvlo = 0, pa = 0, pb = 0, stby = 0, ss = 0;
  logic [CW-1:0] code = 12'd2000, vref = 12'd2000;
  logic gate, boost, pull, dis;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfc_gate_sup #(.PERIOD_CYC(P), .CODE_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwm_req_i(pwm),
    .vout_code_i(code), .vref_code_i(vref),
    .ovp_hi_i(ovp), .pk_ilim_i(pcl), .uvlo_i(uvlo),
    .pin_flt_a_i(pa), .pin_flt_b_i(pb), .standby_i(stby), .ss_start_i(ss),
    .gate_o(gate), .gain_boost_o(boost), .comp_pull_o(pull), .comp_dis_o(dis)
  );

  // behavioural reference
  int m_cnt; bit m_term, m_inh, m_lock, m_gate, m_boost, m_pull, m_dis;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_term = 0; m_inh = 1; m_lock = 0;
      m_gate = 0; m_boost = 0; m_pull = 0; m_dis = 0;
    end else begin
      int c, r; bit lat, fast;
      c = 100 * int'(code); r = int'(vref);
      lat  = uvlo | pa | pb | stby;
      fast = ovp | pcl;
      m_gate  = pwm && (m_cnt < MAXON) && !fast && !m_term && !m_inh && !lat && !m_lock;
      m_term  = (m_cnt == P-1) ? 0 : (m_term | fast);
      m_inh   = lat ? 1 : (ss ? 0 : m_inh);
      m_dis   = lat;
      m_boost = (c > 105*r) || (c < 95*r);
      m_pull  = (c > 107*r);
      if (c > 109*r)      m_lock = 1;
      else if (c < 102*r) m_lock = 0;
      m_cnt   = (m_cnt == P-1) ? 0 : m_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  int run_hi = 0, max_hi = 0;
  always @(negedge clk) if (!done) begin
    chk("gate_o R1 R2 R3 R4 R5 R9", gate, m_gate);
    chk("gain_boost_o R7", boost, m_boost);
    chk("comp_pull_o R8", pull, m_pull);
    chk("comp_dis_o R6", dis, m_dis);
    if (gate) begin run_hi++; if (run_hi > max_hi) max_hi = run_hi; end
    else run_hi = 0;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic strobe_ss();
    ss = 1; cyc(1); ss = 0;
  endtask

  task automatic latch_test(input int which);
    case (which)
      0: uvlo = 1; 1: pa = 1; 2: pb = 1; default: stby = 1;
    endcase
    cyc(1); #1;
    chk("R4 gate cut by latching fault", gate, 1'b0);
    chk("R6 discharge raised", dis, 1'b1);
    cyc(5);
    strobe_ss();           // strobe while fault still present
    cyc(P + 5); #1;
    chk("R5 no release while fault present", gate, 1'b0);
    uvlo = 0; pa = 0; pb = 0; stby = 0;
    cyc(P + 5); #1;
    chk("R5 inhibit held without strobe", gate, 1'b0);
    chk("R6 discharge dropped", dis, 1'b0);
    strobe_ss();
    cyc(P + 2);
    max_hi = 0;
    cyc(P); #1;
    chk("R5 gate resumes after strobe", logic'(max_hi > 0), 1'b1);
  endtask

  initial begin
    cyc(3); #1;
    chk("R10 gate low in reset", gate, 1'b0);
    chk("R10 boost low in reset", boost, 1'b0);
    rst_n = 1;
    pwm = 1;
    cyc(2 * P); #1;
    chk("R10 gate held off until strobe", logic'(max_hi == 0), 1'b1);

    strobe_ss();
    cyc(P + 2);
    max_hi = 0;
    cyc(3 * P); #1;
    chk("R1 longest on-run equals MAX_ON", logic'(max_hi == MAXON), 1'b1);

    // R2: request toggling
    for (int i = 0; i < 40; i++) begin pwm = i[0] ^ i[2]; cyc(1); end
    pwm = 1;
    cyc(P);

    // R3: fast faults mid-period
    cyc(13); ovp = 1; cyc(1); ovp = 0; #1;
    chk("R3 ovp cuts gate", gate, 1'b0);
    cyc(20); pcl = 1; cyc(1); pcl = 0;
    cyc(3 * P);
    max_hi = 0;
    cyc(2 * P); #1;
    chk("R3 gate returns after fast fault", logic'(max_hi == MAXON), 1'b1);

    for (int w = 0; w < 4; w++) latch_test(w);

    // R7/R8/R9: code sweep, ref 2000
    for (int v = 1800; v <= 2300; v += 5) begin code = 12'(v); cyc(1); end
    cyc(2); #1;
    chk("R9 lock set above 109%", gate, 1'b0);
    chk("R8 pull-down above 107%", pull, 1'b1);
    code = 12'd2100; cyc(P); #1;
    chk("R9 lock holds at 105%", gate, 1'b0);
    chk("R8 pull-down off at 105%", pull, 1'b0);
    code = 12'd2041; cyc(P); #1;
    chk("R9 lock holds at 102.05%", gate, 1'b0);
    chk("R7 boost off inside band", boost, 1'b0);
    code = 12'd2030; cyc(2 * P);
    max_hi = 0; cyc(P); #1;
    chk("R9 lock released below 102%", logic'(max_hi > 0), 1'b1);
    for (int v = 2300; v >= 1800; v -= 7) begin code = 12'(v); cyc(1); end
    #1;
    chk("R7 boost below 95%", boost, 1'b1);
    code = 12'd1900; cyc(2); #1;
    chk("R7 boost off at exactly 95%", boost, 1'b0);
    code = 12'd2000; cyc(10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule